// File: doc/BRIEF.md
# Full-Bridge Complementary PWM Generator

This block drives the four gates of a full-bridge (H-bridge) IGBT power stage from a fixed-rate carrier. A free-running tick counter splits each carrier period into two halves. In the first half one diagonal pair of switches conducts; in the second half the opposite diagonal pair conducts. The on-time in each half comes from an effort value produced by the upstream PID regulator. Each pulse starts a programmable dead time after the half begins. The pulse is clamped so that it ends no later than the half boundary. As a result, the two switches of a leg are always separated by at least the dead time.

New effort and dead-time values are taken only at a period boundary, or while the block is disabled. Every period therefore carries whole, symmetric pulses. An arc-detect input, or dropping the enable, forces all four gates low on the very next clock edge. Dropping the enable also restarts the carrier from tick zero. The gate outputs are registered and feed the downstream fault-handling logic.

With the default parameters the carrier is 2000 ticks of a 40 MHz clock, which gives 20 kHz.

Top module: `hbridge_pwm`

## Requirements
- R1: While reset is asserted, and afterwards until enable is sampled high, all four gate outputs are 0.
- R2: The carrier is PERIOD ticks (default 2000) split into two halves of HALF = PERIOD/2 ticks. The k-th consecutive clock edge at which enable is sampled high drives the outputs for tick k mod PERIOD. The first such edge after enable rises drives tick 0.
- R3: Bit mapping: gate bit 0 is the leg-A high switch, bit 1 the leg-A low switch, bit 2 the leg-B high switch, bit 3 the leg-B low switch. In the first half (ticks 0..HALF-1) only bits 0 and 3 may be on. In the second half only bits 1 and 2 may be on. Bit 0 always equals bit 3, and bit 1 always equals bit 2.
- R4: Within a half, let L be the tick offset from the start of that half. The active pair is on exactly when D <= L < D + W, where D is the latched dead time and W is the latched on-time.
- R5: The on-time is W = min(effort, HALF - D). When D >= HALF, W = 0 and all gates stay off.
- R6: The two switches of one leg are never on together. The gap between one turning off and its partner turning on is at least D ticks.
- R7: Effort and dead time are captured only at the edge that drives tick PERIOD-1, or at any edge where enable is low. A change at any other time has no effect until the next period.
- R8: An edge at which arc_det is high drives all four gates to 0. The carrier keeps counting, and the normal pattern resumes at the first edge where arc_det is low again.
- R9: An edge at which enable is low drives all four gates to 0 and returns the carrier to tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low blanks the gates and rewinds the carrier |
| arc_det | input | 1 | Arc detected; blanks all gates at the next edge |
| effort | input | EW (11) | Requested on-time per half, in ticks, from the regulator |
| dead_clks | input | DW (10) | Dead time in ticks |
| gate | output | 4 | Gate drives: bit0 A-high, bit1 A-low, bit2 B-high, bit3 B-low |

## Verification
A reference model of the tick counter and the pulse window predicts every output word, and the predictions are compared cycle by cycle. Steady effort with a moderate dead time shows window placement and pair alternation. An effort change in mid-period separates loading at the boundary from loading at once. Oversized efforts and a dead time of a full half exercise the clamp and the all-off case. Zero dead time with full on-time probes whether the legs still avoid overlap at the half edge. Short arc pulses inside a live pulse, and an enable drop in mid-period, tell blanking-only behaviour (the counter keeps its place) apart from a carrier restart.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  // Which half of the carrier period a switch conducts in
  typedef enum logic {
    HALF_FWD = 1'b0,
    HALF_REV = 1'b1
  } half_e;

  localparam int NUM_SW = 4;

  // On-time limited so the pulse ends at or before the half boundary
  function automatic int clamp_on_time(int req, int dead, int half_len);
    int room;
    if (dead >= half_len) return 0;
    room = half_len - dead;
    return (req > room) ? room : req;
  endfunction

endpackage

// File: rtl/hbp_carrier.sv
module hbp_carrier #(
  parameter int PERIOD = 2000,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] tick,
  output logic          wrap
);

  assign wrap = (tick == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
    end else if (!en || wrap) begin
      tick <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

endmodule

// File: rtl/hbp_setpoint.sv
module hbp_setpoint #(
  parameter int PERIOD = 2000,
  parameter int EW     = 11,
  parameter int DW     = 10,
  localparam int CW    = $clog2(PERIOD),
  localparam int HALF  = PERIOD / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [EW-1:0] effort,
  input  logic [DW-1:0] dead_in,
  output logic [CW-1:0] on_w,
  output logic [DW-1:0] on_d
);

  logic [CW-1:0] w_next;

  always_comb begin
    w_next = CW'(hbp_pkg::clamp_on_time(int'(effort), int'(dead_in), HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_w <= '0;
      on_d <= '0;
    end else if (load) begin
      on_w <= w_next;
      on_d <= dead_in;
    end
  end

endmodule

// File: rtl/hbp_switch_map.sv
module hbp_switch_map #(
  parameter int PERIOD = 2000,
  parameter int DW     = 10,
  localparam int CW    = $clog2(PERIOD),
  localparam int HALF  = PERIOD / 2
) (
  input  logic [CW-1:0]               tick,
  input  logic [CW-1:0]               on_w,
  input  logic [DW-1:0]               on_d,
  output logic [hbp_pkg::NUM_SW-1:0]  pattern
);

  hbp_pkg::half_e cur_half;
  logic           in_window;
  int             offs;

  always_comb begin
    cur_half  = (int'(tick) >= HALF) ? hbp_pkg::HALF_REV : hbp_pkg::HALF_FWD;
    offs      = (cur_half == hbp_pkg::HALF_REV) ? int'(tick) - HALF : int'(tick);
    in_window = (offs >= int'(on_d)) && (offs < int'(on_d) + int'(on_w));
  end

  // Switches 0 and 3 form the forward diagonal, 1 and 2 the reverse one
  for (genvar s = 0; s < hbp_pkg::NUM_SW; s++) begin : g_sw
    localparam hbp_pkg::half_e SW_HALF =
      (s == 0 || s == 3) ? hbp_pkg::HALF_FWD : hbp_pkg::HALF_REV;
    assign pattern[s] = in_window && (cur_half == SW_HALF);
  end

endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm #(
  parameter int PERIOD = 2000,
  parameter int EW     = 11,
  parameter int DW     = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          arc_det,
  input  logic [EW-1:0] effort,
  input  logic [DW-1:0] dead_clks,
  output logic [3:0]    gate
);

  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] tick;
  logic          wrap;
  logic [CW-1:0] on_w;
  logic [DW-1:0] on_d;
  logic [3:0]    pattern;
  logic          blank;
  logic          load;

  assign blank = !en || arc_det;
  assign load  = !en || wrap;

  hbp_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .tick (tick),
    .wrap (wrap)
  );

  hbp_setpoint #(.PERIOD(PERIOD), .EW(EW), .DW(DW)) u_setpoint (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .effort  (effort),
    .dead_in (dead_clks),
    .on_w    (on_w),
    .on_d    (on_d)
  );

  hbp_switch_map #(.PERIOD(PERIOD), .DW(DW)) u_map (
    .tick    (tick),
    .on_w    (on_w),
    .on_d    (on_d),
    .pattern (pattern)
  );

  always_ff @(posedge clk) begin
    if (rst || blank) begin
      gate <= '0;
    end else begin
      gate <= pattern;
    end
  end

endmodule

// File: rtl/hbp_checker.sv
module hbp_checker (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       arc_det,
  input logic [3:0] gate
);

  // R6
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate[0] && gate[1]));

  // R6
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate[2] && gate[3]));

  // R3
  diag_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (gate[0] == gate[3]) && (gate[1] == gate[2]));

  // R8
  arc_blank_chk: assert property (@(posedge clk) disable iff (rst)
    arc_det |=> (gate == 4'b0000));

  // R9
  en_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate == 4'b0000));

endmodule

bind hbridge_pwm hbp_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .arc_det (arc_det),
  .gate    (gate)
);

// File: tb/test_hbridge_pwm.sv
module test_hbridge_pwm;

  localparam int PERIOD = 2000;
  localparam int HALF   = PERIOD / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        arc_det = 1'b0;
  logic [10:0] effort = '0;
  logic [9:0]  dead_clks = '0;
  logic [3:0]  gate;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [3:0] q_exp[$];
  string      q_tag[$];

  // reference model state
  int m_t = 0;
  int m_w = 0;
  int m_d = 0;

  hbridge_pwm i_hbridge_pwm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .arc_det   (arc_det),
    .effort    (effort),
    .dead_clks (dead_clks),
    .gate      (gate)
  );

  always #10ns clk = ~clk;

  function automatic int ref_clamp(int e, int d);
    if (d >= HALF) return 0;
    if (e > HALF - d) return HALF - d;
    return e;
  endfunction

  function automatic logic [3:0] ref_gate(int t, int w, int d);
    int  loc;
    bit  on;
    loc = t % HALF;
    on  = (loc >= d) && (loc < d + w);
    if (t >= HALF) return {1'b0, on, on, 1'b0};
    return {on, 1'b0, 1'b0, on};
  endfunction

  task automatic step(input bit e, input bit a, input int eff, input int dt, input string tag);
    logic [3:0] exp_g;
    @(negedge clk);
    rst       = 1'b0;
    en        = e;
    arc_det   = a;
    effort    = 11'(eff);
    dead_clks = 10'(dt);
    exp_g = (e && !a) ? ref_gate(m_t, m_w, m_d) : 4'b0000;
    q_exp.push_back(exp_g);
    q_tag.push_back(tag);
    if (!e || m_t == PERIOD - 1) begin
      m_w = ref_clamp(eff, dt);
      m_d = dt;
    end
    m_t = !e ? 0 : ((m_t == PERIOD - 1) ? 0 : m_t + 1);
  endtask

  task automatic run(input int n, input bit e, input bit a, input int eff, input int dt,
                     input string tag);
    for (int i = 0; i < n; i++) step(e, a, eff, dt, tag);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1ns;
    if (q_exp.size() > 0) begin
      logic [3:0] e;
      string      t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      tests++;
      if (gate !== e) begin
        fails++;
        $display("FAIL %s: gate=%b expected=%b at t=%0t", t, gate, e, $time);
      end
      tests++;
      if ((gate[0] && gate[1]) || (gate[2] && gate[3])) begin
        fails++;
        $display("FAIL R6: leg overlap gate=%b expected no overlap", gate);
      end
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    tests++;
    if (gate !== 4'b0000) begin
      fails++;
      $display("FAIL R1: gate=%b expected=0000 in reset", gate);
    end
    // R1 / R9: disabled after reset
    run(3, 1'b0, 1'b0, 300, 40, "R1");
    // R2, R3, R4: steady operation
    run(2000, 1'b1, 1'b0, 300, 40, "R2");
    run(2000, 1'b1, 1'b0, 300, 40, "R3");
    // R7: mid-period change shows only from the next period
    run(500, 1'b1, 1'b0, 300, 40, "R7");
    run(1500, 1'b1, 1'b0, 900, 40, "R7");
    run(2000, 1'b1, 1'b0, 900, 40, "R4");
    // R5: clamp to HALF - D, then D >= HALF gives nothing
    run(2000, 1'b1, 1'b0, 2000, 100, "R5");
    run(2000, 1'b1, 1'b0, 2000, 100, "R5");
    run(2000, 1'b1, 1'b0, 500, 1000, "R5");
    run(2000, 1'b1, 1'b0, 500, 1000, "R5");
    // R6: zero dead time, full on-time
    run(2000, 1'b1, 1'b0, 1000, 0, "R6");
    run(2000, 1'b1, 1'b0, 1000, 0, "R6");
    // R8: arc pulses inside live pulses, counter keeps running
    run(2000, 1'b1, 1'b0, 600, 40, "R4");
    run(100, 1'b1, 1'b0, 600, 40, "R8");
    run(3, 1'b1, 1'b1, 600, 40, "R8");
    run(1000, 1'b1, 1'b0, 600, 40, "R8");
    run(5, 1'b1, 1'b1, 600, 40, "R8");
    run(892, 1'b1, 1'b0, 600, 40, "R8");
    // R9: enable drop in mid-period restarts at tick 0
    run(300, 1'b1, 1'b0, 600, 40, "R9");
    run(5, 1'b0, 1'b0, 200, 40, "R9");
    run(2000, 1'b1, 1'b0, 200, 40, "R9");
    run(3, 1'b0, 1'b0, 200, 40, "R9");
    repeat (3) @(posedge clk);
    #2ns;
    tests++;
    if (q_exp.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d expected items left, expected 0", q_exp.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule